// File: doc/BRIEF.md
# PTP Event Timestamp Capture Queue

This block keeps a short queue of start-of-packet timestamps for precision-time event messages seen on the transmit and receive paths. A packet parser elsewhere raises a one-cycle strobe together with the message type, the sequence number and the direction. The block qualifies that strobe against per-direction enables and per-message-type action fields. If the strobe qualifies, it stores the current seconds and nanoseconds alongside the parsed fields as one queue entry.

Software drains the queue through a small register window. Writing the open bit copies the oldest entry into a frozen readout image. Software then reads the time words, the sequence number and an info word. Writing the close bit discards that entry, and a following write of zero rearms the window. A pending flag, on a port and in the status register, tells software that work is waiting. A sticky flag records any capture that was lost because the queue was full.

The readout is controlled by a three-state machine:
- `RD_IDLE` (encoding 0): the window is closed.
- `RD_HOLD` (encoding 1): the image is frozen.
- `RD_CLOSE` (encoding 2): the entry has been popped and the window waits for the zero write.

The transitions are:
- `RD_IDLE` to `RD_HOLD`: open written while the queue is non-empty.
- `RD_HOLD` to `RD_CLOSE`: close written, which pops the head entry.
- `RD_CLOSE` to `RD_IDLE`: a zero written to the read-control register.

Every other write leaves the state unchanged.

Top module: `ptp_evt_ts_queue`

## Requirements
- R1: After reset, every configuration register reads 0, status reads 0, `ts_pending` is low and the read-control register reads state 0 (`RD_IDLE`).
- R2: Control register (address 0) bit 0 enables transmit capture and bit 8 enables receive capture; a strobe for a disabled direction leaves the queue unchanged.
- R3: The transmit-mode (address 1) and receive-mode (address 2) registers each hold a 2-bit action field per event type t (0 to 3). The field for port use sits at bits 2t+1:2t and the field for CPU use at bits 2t+9:2t+8. A strobe is stored only if either field for its type is non-zero. Types 4 to 15 are never stored.
- R4: A stored entry holds `cur_sec`/`cur_nsec` as sampled at the clock edge of the strobe, plus the strobe's sequence number, type and direction.
- R5: Status (address 4) bit 1 and `ts_pending` are high exactly while at least one entry is queued.
- R6: Entries leave in arrival order, and the queue holds at most DEPTH entries.
- R7: A qualified strobe that arrives while the queue is full is dropped and sets sticky status bit 2. Writing status with bit 2 set clears that bit.
- R8: Writing read-control (address 3) with bit 0 set while in `RD_IDLE` with a non-empty queue loads the head entry into the readout image and enters `RD_HOLD`. The same write with an empty queue is ignored.
- R9: While in `RD_HOLD`, the readout image does not change, whatever captures arrive.
- R10: A write with bit 1 set in `RD_HOLD` pops the head and enters `RD_CLOSE`. A data-zero write in `RD_CLOSE` returns to `RD_IDLE`. Bit 1 written in any other state pops nothing.
- R11: The readout words are at the following addresses:
  - address 5: nanoseconds bits 15:0
  - address 6: nanoseconds bits 31:16
  - address 7: seconds bits 15:0
  - address 8: seconds bits 31:16
  - address 9: sequence number
  - address 10: info word, with the type in bits 15:12 and bit 11 set for transmit.

  Read-control reads back the state in bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sop_valid | input | 1 | Start-of-packet strobe for a parsed event message |
| sop_tx | input | 1 | Strobe direction, 1 = transmit |
| sop_type | input | 4 | Parsed message type |
| sop_seq | input | 16 | Parsed sequence number |
| cur_sec | input | 32 | Current time, seconds |
| cur_nsec | input | 32 | Current time, nanoseconds |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| ts_pending | output | 1 | At least one entry is queued |

## Verification
The bench builds the block with DEPTH set to 4, so that a full queue and a dropped capture take only a handful of strobes. Draining and refilling across several phases moves the queue pointers through their wrap point more than once. Holding the readout open while further strobes land shows that the frozen image and the queue order are independent. The same small depth lets the bench show that a capture blocked by the full condition never reappears in the drained sequence.

// File: rtl/ptp_tsq_pkg.sv
package ptp_tsq_pkg;

    localparam int SEC_W  = 32;
    localparam int NS_W   = 32;
    localparam int SEQ_W  = 16;
    localparam int TYPE_W = 4;
    localparam int REG_W  = 16;
    localparam int ADDR_W = 4;

    // register addresses
    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] A_TXMODE = 4'd1;
    localparam logic [ADDR_W-1:0] A_RXMODE = 4'd2;
    localparam logic [ADDR_W-1:0] A_RDCTL  = 4'd3;
    localparam logic [ADDR_W-1:0] A_STAT   = 4'd4;
    localparam logic [ADDR_W-1:0] A_NS_LO  = 4'd5;
    localparam logic [ADDR_W-1:0] A_NS_HI  = 4'd6;
    localparam logic [ADDR_W-1:0] A_S_LO   = 4'd7;
    localparam logic [ADDR_W-1:0] A_S_HI   = 4'd8;
    localparam logic [ADDR_W-1:0] A_SEQ    = 4'd9;
    localparam logic [ADDR_W-1:0] A_INFO   = 4'd10;

    // bit positions
    localparam int B_TX_EN   = 0;
    localparam int B_RX_EN   = 8;
    localparam int B_OPEN    = 0;
    localparam int B_CLOSE   = 1;
    localparam int B_PENDING = 1;
    localparam int B_OVF     = 2;

    typedef struct packed {
        logic [SEC_W-1:0]  sec;
        logic [NS_W-1:0]   nsec;
        logic [SEQ_W-1:0]  seq;
        logic [TYPE_W-1:0] mtype;
        logic              dir_tx;
    } tsq_entry_t;

    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_HOLD  = 2'd1,
        RD_CLOSE = 2'd2
    } rd_state_t;

endpackage

// File: rtl/tsq_filter.sv
module tsq_filter
    import ptp_tsq_pkg::*;
#(
    parameter int NUM_EVT = 4,
    parameter int CPU_OFS = 8
) (
    input  logic              sop_valid,
    input  logic              sop_tx,
    input  logic [TYPE_W-1:0] sop_type,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic [REG_W-1:0]  tx_mode,
    input  logic [REG_W-1:0]  rx_mode,
    output logic              accept
);
    logic [REG_W-1:0]   mode_sel;
    logic [NUM_EVT-1:0] type_hit;

    assign mode_sel = sop_tx ? tx_mode : rx_mode;

    // one qualifier per event message type
    for (genvar t = 0; t < NUM_EVT; t++) begin : g_evt
        assign type_hit[t] = (sop_type == TYPE_W'(t)) &&
                             ((|mode_sel[2*t +: 2]) || (|mode_sel[CPU_OFS + 2*t +: 2]));
    end

    assign accept = sop_valid && (sop_tx ? tx_en : rx_en) && (|type_hit);
endmodule

// File: rtl/tsq_fifo.sv
module tsq_fifo
    import ptp_tsq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  tsq_entry_t   din,
    input  logic         pop,
    output tsq_entry_t   head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    tsq_entry_t      mem [DEPTH];
    logic [PW-1:0]   wr_ptr, rd_ptr;
    logic            do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= nxt(wr_ptr);
            if (do_pop)  rd_ptr <= nxt(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end
endmodule

// File: rtl/tsq_reader.sv
module tsq_reader
    import ptp_tsq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       open_wr,
    input  logic       close_wr,
    input  logic       zero_wr,
    input  logic       q_empty,
    input  tsq_entry_t q_head,
    output logic       pop,
    output rd_state_t  state,
    output tsq_entry_t image
);
    rd_state_t state_nx;
    logic      load;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RD_IDLE;
        else        state <= state_nx;
    end

    // next state and outputs
    always_comb begin
        state_nx = state;
        load     = 1'b0;
        pop      = 1'b0;
        unique case (state)
            RD_IDLE: begin
                if (open_wr && !q_empty) begin
                    load     = 1'b1;
                    state_nx = RD_HOLD;
                end
            end
            RD_HOLD: begin
                if (close_wr) begin
                    pop      = 1'b1;
                    state_nx = RD_CLOSE;
                end
            end
            RD_CLOSE: begin
                if (zero_wr) state_nx = RD_IDLE;
            end
            default: state_nx = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    image <= '0;
        else if (load) image <= q_head;
    end
endmodule

// File: rtl/ptp_evt_ts_queue.sv
module ptp_evt_ts_queue
    import ptp_tsq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sop_valid,
    input  logic              sop_tx,
    input  logic [TYPE_W-1:0] sop_type,
    input  logic [SEQ_W-1:0]  sop_seq,
    input  logic [SEC_W-1:0]  cur_sec,
    input  logic [NS_W-1:0]   cur_nsec,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              ts_pending
);
    localparam int CW = $clog2(DEPTH+1);

    logic [REG_W-1:0] ctrl_q, txmode_q, rxmode_q;
    logic             ovf_flag, ovf_clr;
    logic             accept, q_full, q_empty, pop;
    logic [CW-1:0]    fill_cnt;
    logic             open_wr, close_wr, zero_wr;
    tsq_entry_t       new_entry, q_head, image;
    rd_state_t        rd_state;

    assign open_wr  = reg_wr && reg_addr == A_RDCTL && reg_wdata[B_OPEN];
    assign close_wr = reg_wr && reg_addr == A_RDCTL && reg_wdata[B_CLOSE];
    assign zero_wr  = reg_wr && reg_addr == A_RDCTL && reg_wdata == '0;
    assign ovf_clr  = reg_wr && reg_addr == A_STAT  && reg_wdata[B_OVF];

    tsq_filter u_filter (
        .sop_valid (sop_valid),
        .sop_tx    (sop_tx),
        .sop_type  (sop_type),
        .tx_en     (ctrl_q[B_TX_EN]),
        .rx_en     (ctrl_q[B_RX_EN]),
        .tx_mode   (txmode_q),
        .rx_mode   (rxmode_q),
        .accept    (accept)
    );

    assign new_entry = '{sec: cur_sec, nsec: cur_nsec, seq: sop_seq,
                         mtype: sop_type, dir_tx: sop_tx};

    tsq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (accept),
        .din   (new_entry),
        .pop   (pop),
        .head  (q_head),
        .count (fill_cnt),
        .full  (q_full),
        .empty (q_empty)
    );

    tsq_reader u_reader (
        .clk      (clk),
        .rst_n    (rst_n),
        .open_wr  (open_wr),
        .close_wr (close_wr),
        .zero_wr  (zero_wr),
        .q_empty  (q_empty),
        .q_head   (q_head),
        .pop      (pop),
        .state    (rd_state),
        .image    (image)
    );

    // configuration and sticky overflow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            txmode_q <= '0;
            rxmode_q <= '0;
            ovf_flag <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == A_CTRL)   ctrl_q   <= reg_wdata;
            if (reg_wr && reg_addr == A_TXMODE) txmode_q <= reg_wdata;
            if (reg_wr && reg_addr == A_RXMODE) rxmode_q <= reg_wdata;
            if (accept && q_full)  ovf_flag <= 1'b1;
            else if (ovf_clr)      ovf_flag <= 1'b0;
        end
    end

    assign ts_pending = !q_empty;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL:   reg_rdata = ctrl_q;
            A_TXMODE: reg_rdata = txmode_q;
            A_RXMODE: reg_rdata = rxmode_q;
            A_RDCTL:  reg_rdata = REG_W'(rd_state);
            A_STAT: begin
                reg_rdata[B_PENDING] = ts_pending;
                reg_rdata[B_OVF]     = ovf_flag;
            end
            A_NS_LO:  reg_rdata = image.nsec[15:0];
            A_NS_HI:  reg_rdata = image.nsec[31:16];
            A_S_LO:   reg_rdata = image.sec[15:0];
            A_S_HI:   reg_rdata = image.sec[31:16];
            A_SEQ:    reg_rdata = image.seq;
            A_INFO:   reg_rdata = {image.mtype, image.dir_tx, 11'd0};
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ptp_evt_ts_queue_chk.sv
module ptp_evt_ts_queue_chk
    import ptp_tsq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       accept,
    input logic                       ovf_flag,
    input logic                       ovf_clr,
    input logic [$clog2(DEPTH+1)-1:0] fill_cnt,
    input rd_state_t                  rd_state,
    input tsq_entry_t                 image,
    input logic                       close_wr,
    input logic                       ts_pending
);
    assert_depth_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= ($clog2(DEPTH+1))'(DEPTH));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && fill_cnt == ($clog2(DEPTH+1))'(DEPTH)) |=> ovf_flag);

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    assert_image_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_state == RD_HOLD) |=> $stable(image));

    assert_pop_only_close_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(close_wr && rd_state == RD_HOLD) |=> fill_cnt >= $past(fill_cnt));

    assert_pending_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && fill_cnt == '0) |=> ts_pending);
endmodule

bind ptp_evt_ts_queue ptp_evt_ts_queue_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .ovf_flag   (ovf_flag),
    .ovf_clr    (ovf_clr),
    .fill_cnt   (fill_cnt),
    .rd_state   (rd_state),
    .image      (image),
    .close_wr   (close_wr),
    .ts_pending (ts_pending)
);

// File: tb/sim_ptp_evt_ts_queue.sv
module sim_ptp_evt_ts_queue;
    import ptp_tsq_pkg::*;

    localparam int CLK_P = 10;
    localparam int DEPTH = 4;

    logic        clk = 0, rst_n = 0;
    logic        sop_valid = 0, sop_tx = 0;
    logic [3:0]  sop_type = 0;
    logic [15:0] sop_seq = 0;
    logic [31:0] cur_sec = 0, cur_nsec = 0;
    logic        reg_wr = 0;
    logic [3:0]  reg_addr = 0;
    logic [15:0] reg_wdata = 0;
    logic [15:0] reg_rdata;
    logic        ts_pending;

    int checks = 0, fails = 0;
    tsq_entry_t sb[$];
    logic [15:0] m_ctrl = 0, m_tx = 0, m_rx = 0;

    always #(CLK_P/2) clk = ~clk;

    ptp_evt_ts_queue #(.DEPTH(DEPTH)) u0 (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        if (a == A_CTRL) m_ctrl = d;
        if (a == A_TXMODE) m_tx = d;
        if (a == A_RXMODE) m_rx = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // driver: applies a strobe and predicts acceptance from R2/R3/R6/R7
    task automatic capture(logic tx, logic [3:0] ty, logic [15:0] sq,
                           logic [31:0] s, logic [31:0] ns);
        logic [15:0] md;
        logic        ok;
        md = tx ? m_tx : m_rx;
        ok = (tx ? m_ctrl[0] : m_ctrl[8]) && ty < 4 &&
             ((md[2*ty +: 2] != 0) || (md[8 + 2*ty +: 2] != 0));
        @(negedge clk);
        sop_valid = 1; sop_tx = tx; sop_type = ty; sop_seq = sq;
        cur_sec = s; cur_nsec = ns;
        @(negedge clk);
        sop_valid = 0; cur_sec = s + 1; cur_nsec = ns + 7;
        if (ok && sb.size() < DEPTH) sb.push_back('{sec: s, nsec: ns, seq: sq, mtype: ty, dir_tx: tx});
    endtask

    task automatic read_image(tsq_entry_t e, string req);
        logic [15:0] d;
        rd(A_NS_LO, d); chk({req, " ns_lo"}, d, e.nsec[15:0]);
        rd(A_NS_HI, d); chk({req, " ns_hi"}, d, e.nsec[31:16]);
        rd(A_S_LO, d);  chk({req, " s_lo"}, d, e.sec[15:0]);
        rd(A_S_HI, d);  chk({req, " s_hi"}, d, e.sec[31:16]);
        rd(A_SEQ, d);   chk({req, " seq"}, d, e.seq);
        rd(A_INFO, d);  chk({req, " info R11"}, d, {e.mtype, e.dir_tx, 11'd0});
    endtask

    // monitor side: pop the expected item and compare the full readout
    task automatic drain_one(string req);
        tsq_entry_t e;
        logic [15:0] d;
        e = sb.pop_front();
        wr(A_RDCTL, 16'h0001);
        rd(A_RDCTL, d); chk("R8 hold state", d, 16'd1);
        read_image(e, req);
        wr(A_RDCTL, 16'h0002);
        rd(A_RDCTL, d); chk("R10 close state", d, 16'd2);
        wr(A_RDCTL, 16'h0000);
        rd(A_RDCTL, d); chk("R10 idle state", d, 16'd0);
    endtask

    initial begin
        #(CLK_P * 100000);
        fails++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(A_CTRL, d);   chk("R1 ctrl", d, 0);
        rd(A_TXMODE, d); chk("R1 txmode", d, 0);
        rd(A_STAT, d);   chk("R1 status", d, 0);
        rd(A_RDCTL, d);  chk("R1 state", d, 0);
        chk("R1 pending", ts_pending, 0);

        wr(A_CTRL, 16'h0101);
        wr(A_TXMODE, 16'h00FF);
        wr(A_RXMODE, 16'h0C01);   // rx: Sync by port field, Delay_Req by CPU field
        capture(1, 0, 16'd10, 32'h0001_0002, 32'h1234_5678);  // R4 tx sync
        capture(0, 1, 16'd11, 32'hA000_0003, 32'h0BCD_EF01);  // R3 cpu field
        capture(0, 2, 16'd12, 32'h5, 32'h6);                  // R3 zero field
        capture(1, 8, 16'd13, 32'h7, 32'h8);                  // R3 non-event
        rd(A_STAT, d); chk("R5 status pending", d, 16'h0002);
        chk("R5 pending port", ts_pending, 1);
        drain_one("R4 R6 first");
        drain_one("R4 R3 second");
        rd(A_STAT, d); chk("R3 R5 drained", d, 0);
        chk("R5 pending low", ts_pending, 0);

        // R2 receive disabled
        wr(A_CTRL, 16'h0001);
        capture(0, 0, 16'd20, 32'h9, 32'h9);
        chk("R2 rx disabled", ts_pending, 0);

        // R8 open on empty ignored, R10 close in idle pops nothing
        wr(A_RDCTL, 16'h0001);
        rd(A_RDCTL, d); chk("R8 empty open", d, 0);
        capture(1, 3, 16'd21, 32'h11, 32'h22);
        wr(A_RDCTL, 16'h0002);
        chk("R10 idle close no pop", ts_pending, 1);
        wr(A_RDCTL, 16'h0000);
        drain_one("R10 survivor");

        // R9 frozen image
        wr(A_CTRL, 16'h0101);
        capture(1, 1, 16'd30, 32'h100, 32'h200);
        capture(0, 0, 16'd31, 32'h300, 32'h400);
        wr(A_RDCTL, 16'h0001);
        read_image(sb[0], "R9 before");
        capture(1, 2, 16'd32, 32'h500, 32'h600);
        read_image(sb[0], "R9 after");
        void'(sb.pop_front());
        wr(A_RDCTL, 16'h0002);
        wr(A_RDCTL, 16'h0000);
        drain_one("R6 order after hold");
        drain_one("R6 third");

        // R7 overflow
        for (int i = 0; i < DEPTH + 1; i++)
            capture(1, 0, 16'(40 + i), 32'(i), 32'(100 + i));
        rd(A_STAT, d); chk("R7 overflow set", d, 16'h0006);
        for (int i = 0; i < DEPTH; i++) drain_one("R6 R7 fill");
        rd(A_STAT, d); chk("R7 sticky", d, 16'h0004);
        wr(A_STAT, 16'h0004);
        rd(A_STAT, d); chk("R7 cleared", d, 0);
        chk("R6 scoreboard empty", sb.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule